// File: doc/BRIEF.md
# Instruction Reuse Classifier Table

This block keeps a learned reuse score for each memory-access instruction of a program. A hash of the instruction's program counter selects one of 512 saturating 8-bit counters. When the cache logic reports that an access by that instruction touched a line already used before (a reuse event), the counter moves up. When the access touches a line for the first time, the counter moves down. Instructions whose accesses keep coming back to the same data therefore build high scores, and streaming instructions sink towards zero.

A separate lookup port turns the score of any instruction into one of five classes, from "almost never reused" to "reused almost every time". An insertion or bypass policy reads this class for the instruction that caused a miss. The lookup is combinational on the current table contents, so a lookup and an update to the same entry in one cycle see the old score. The new score takes effect at the clock edge.

Top module: `reuse_filter_table`

## Requirements
- R1: After reset every counter holds 128, so every lookup returns class NORMAL (code 2) until an update reaches its entry.
- R2: A cycle with the reuse pulse high and the first-touch pulse low adds one to the selected counter, and the counter stays at 255 once it is there.
- R3: A cycle with the first-touch pulse high and the reuse pulse low subtracts one from the selected counter, and the counter stays at 0 once it is there.
- R4: A cycle with both pulses high, or with both low, leaves every counter unchanged.
- R5: The entry index is program-counter bits [8:0] XOR bits [17:9]. Bits above 17 are ignored, so two program counters with equal hashes share one counter.
- R6: The class codes are BYPASS=0 for a counter below 16, USELESS=1 below 96, NORMAL=2 below 160, USEFUL=3 below 240, and REUSE=4 from 240 to 255. No other code is ever output.
- R7: The lookup class depends only on the lookup program counter and the current table contents, within the same cycle. A same-cycle update to the same entry is not seen until after the next clock edge.
- R8: An update changes only the counter its program counter selects. Entries with other hashes keep their class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| updPc | input | 32 | Program counter of the instruction being trained |
| firstTouch | input | 1 | The access touched its line for the first time |
| reuseHit | input | 1 | The access reused a line that was touched before |
| lookPc | input | 32 | Program counter being classified |
| lookClass | output | 3 | Reuse class of lookPc (0 BYPASS to 4 REUSE) |

## Verification
Long runs of one pulse kind walk a single counter across each class boundary in both directions, one step either side of 16, 96, 160 and 240. Saturation is checked by driving past 0 and past 255 and then stepping back, which separates clamping from wrap-around. Cycles with both pulses, aliased and high-bit-differing program counters, and untouched neighbouring entries separate the hash and the update gating from the counting itself. A lookup that shares a cycle with an update to the same entry shows whether the read path bypasses the register edge.

// File: rtl/rft_pkg.sv
package rft_pkg;

  localparam int RFT_IDX_W = 9;

  typedef enum logic [2:0] {
    CLS_BYPASS  = 3'd0,
    CLS_USELESS = 3'd1,
    CLS_NORMAL  = 3'd2,
    CLS_USEFUL  = 3'd3,
    CLS_REUSE   = 3'd4
  } reuseClass_e;

  typedef struct packed {
    logic                 inc;
    logic                 dec;
    logic [RFT_IDX_W-1:0] idx;
  } updStrobe_t;

endpackage

// File: rtl/rft_ctrl.sv
module rft_ctrl
  import rft_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PC_W-1:0]      updPc,
  input  logic                 firstTouch,
  input  logic                 reuseHit,
  input  logic [PC_W-1:0]      lookPc,
  output updStrobe_t           strobe,
  output logic [RFT_IDX_W-1:0] lookIdx
);

  localparam int HASH_SPAN = 2 * RFT_IDX_W;

  function automatic logic [RFT_IDX_W-1:0] foldPc(input logic [PC_W-1:0] pc);
    logic [HASH_SPAN-1:0] slice;
    slice = pc[HASH_SPAN-1:0];
    return slice[RFT_IDX_W-1:0] ^ slice[HASH_SPAN-1:RFT_IDX_W];
  endfunction

  always_comb begin
    strobe.inc = reuseHit && !firstTouch;
    strobe.dec = firstTouch && !reuseHit;
    strobe.idx = foldPc(updPc);
    lookIdx    = foldPc(lookPc);
  end

  // R4: never both directions in one cycle
  assert_single_dir_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.inc, strobe.dec}));

  // R4: a strobe appears only for exactly one pulse
  assert_strobe_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (firstTouch == reuseHit) |-> !(strobe.inc || strobe.dec));

endmodule

// File: rtl/rft_datapath.sv
module rft_datapath
  import rft_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RST_VAL   = 128,
  parameter int TH_USELESS = 16,
  parameter int TH_NORMAL  = 96,
  parameter int TH_USEFUL  = 160,
  parameter int TH_REUSE   = 240
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  updStrobe_t           strobe,
  input  logic [RFT_IDX_W-1:0] lookIdx,
  output logic [2:0]           lookClass
);

  localparam int ENTRIES = 1 << RFT_IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN  = '0;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_VAL);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt [ENTRIES];
  logic [CNT_W-1:0] curCnt;
  logic [CNT_W-1:0] readCnt;

  assign curCnt  = cnt[strobe.idx];
  assign readCnt = cnt[lookIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) cnt[i] <= CNT_INIT;
    end else if (strobe.inc && curCnt != CNT_MAX) begin
      cnt[strobe.idx] <= curCnt + CNT_ONE;
    end else if (strobe.dec && curCnt != CNT_MIN) begin
      cnt[strobe.idx] <= curCnt - CNT_ONE;
    end
  end

  function automatic reuseClass_e grade(input logic [CNT_W-1:0] v);
    if (int'(v) < TH_USELESS)     return CLS_BYPASS;
    else if (int'(v) < TH_NORMAL) return CLS_USELESS;
    else if (int'(v) < TH_USEFUL) return CLS_NORMAL;
    else if (int'(v) < TH_REUSE)  return CLS_USEFUL;
    else                          return CLS_REUSE;
  endfunction

  always_comb begin
    lookClass = grade(readCnt);
  end

  // R6: only the five defined codes
  always_comb begin
    if (rstN) assert_class_legal_R6: assert (lookClass <= 3'd4);
  end

  // R2: increment by exactly one below the ceiling
  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && curCnt != CNT_MAX) |=> cnt[$past(strobe.idx)] == $past(curCnt) + CNT_ONE);

  // R2: ceiling holds
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && curCnt == CNT_MAX) |=> cnt[$past(strobe.idx)] == CNT_MAX);

  // R3: decrement by exactly one above the floor
  assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && curCnt != CNT_MIN) |=> cnt[$past(strobe.idx)] == $past(curCnt) - CNT_ONE);

  // R3: floor holds
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && curCnt == CNT_MIN) |=> cnt[$past(strobe.idx)] == CNT_MIN);

  // R4: no strobe, selected entry unchanged
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !strobe.dec) |=> cnt[$past(strobe.idx)] == $past(curCnt));

endmodule

// File: rtl/reuse_filter_table.sv
module reuse_filter_table
  import rft_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int CNT_W      = 8,
  parameter int RST_VAL    = 128,
  parameter int TH_USELESS = 16,
  parameter int TH_NORMAL  = 96,
  parameter int TH_USEFUL  = 160,
  parameter int TH_REUSE   = 240
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] updPc,
  input  logic            firstTouch,
  input  logic            reuseHit,
  input  logic [PC_W-1:0] lookPc,
  output logic [2:0]      lookClass
);

  updStrobe_t           strobe;
  logic [RFT_IDX_W-1:0] lookIdx;

  rft_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .updPc      (updPc),
    .firstTouch (firstTouch),
    .reuseHit   (reuseHit),
    .lookPc     (lookPc),
    .strobe     (strobe),
    .lookIdx    (lookIdx)
  );

  rft_datapath #(
    .CNT_W      (CNT_W),
    .RST_VAL    (RST_VAL),
    .TH_USELESS (TH_USELESS),
    .TH_NORMAL  (TH_NORMAL),
    .TH_USEFUL  (TH_USEFUL),
    .TH_REUSE   (TH_REUSE)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lookIdx   (lookIdx),
    .lookClass (lookClass)
  );

endmodule

// File: tb/reuse_filter_table_bench.sv
module reuse_filter_table_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] updPc = '0;
  logic        firstTouch = 1'b0;
  logic        reuseHit = 1'b0;
  logic [31:0] lookPc = '0;
  logic [2:0]  lookClass;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  reuse_filter_table u_reuse_filter_table (
    .clk(clk), .rstN(rstN), .updPc(updPc), .firstTouch(firstTouch),
    .reuseHit(reuseHit), .lookPc(lookPc), .lookClass(lookClass)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        ft;
    logic        ru;
    logic [7:0]  reps;
    logic [31:0] look;
    logic [2:0]  expCls;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R3 / R6 walk down on entry 0x10
    '{32'h10, 1'b1, 1'b0, 8'd32,  32'h10, 3'd2, 4'd6}, // 96 NORMAL
    '{32'h10, 1'b1, 1'b0, 8'd1,   32'h10, 3'd1, 4'd6}, // 95 USELESS
    '{32'h10, 1'b1, 1'b0, 8'd79,  32'h10, 3'd1, 4'd6}, // 16 USELESS
    '{32'h10, 1'b1, 1'b0, 8'd1,   32'h10, 3'd0, 4'd6}, // 15 BYPASS
    '{32'h10, 1'b1, 1'b0, 8'd20,  32'h10, 3'd0, 4'd3}, // floor 0
    '{32'h10, 1'b0, 1'b1, 8'd16,  32'h10, 3'd1, 4'd3}, // 16 after clamp
    // R2 / R6 walk up on entry 0x20
    '{32'h20, 1'b0, 1'b1, 8'd31,  32'h20, 3'd2, 4'd6}, // 159 NORMAL
    '{32'h20, 1'b0, 1'b1, 8'd1,   32'h20, 3'd3, 4'd6}, // 160 USEFUL
    '{32'h20, 1'b0, 1'b1, 8'd79,  32'h20, 3'd3, 4'd6}, // 239 USEFUL
    '{32'h20, 1'b0, 1'b1, 8'd1,   32'h20, 3'd4, 4'd6}, // 240 REUSE
    '{32'h20, 1'b0, 1'b1, 8'd30,  32'h20, 3'd4, 4'd2}, // ceiling 255
    '{32'h20, 1'b1, 1'b0, 8'd16,  32'h20, 3'd3, 4'd2}, // 239 after clamp
    // R4 both pulses, then proof the value is still 128
    '{32'h30, 1'b1, 1'b1, 8'd5,   32'h30, 3'd2, 4'd4},
    '{32'h30, 1'b1, 1'b0, 8'd33,  32'h30, 3'd1, 4'd4}, // 95 only if untouched
    // R5 alias: 0x241 hashes to 0x040
    '{32'h241, 1'b1, 1'b0, 8'd33, 32'h40, 3'd1, 4'd5},
    '{32'h0, 1'b0, 1'b0, 8'd1,    32'h0010_0040, 3'd1, 4'd5}, // high bits ignored
    // R8 neighbour untouched
    '{32'h0, 1'b0, 1'b0, 8'd1,    32'h41, 3'd2, 4'd8}
  };

  task automatic check(input logic [2:0] exp, input int req, input string what);
    checks++;
    if (lookClass !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, lookClass, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; firstTouch = 1'b0; reuseHit = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    resetDut();
    // R1 reset state
    lookPc = 32'h0;      #1 check(3'd2, 1, "reset entry 0");
    lookPc = 32'h1FF;    #1 check(3'd2, 1, "reset entry 511");
    lookPc = 32'hABCDE;  #1 check(3'd2, 1, "reset hashed entry");

    // vector walk
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VECS[v].reps); k++) begin
        @(negedge clk);
        updPc = VECS[v].pc; firstTouch = VECS[v].ft; reuseHit = VECS[v].ru;
      end
      @(negedge clk);
      firstTouch = 1'b0; reuseHit = 1'b0;
      lookPc = VECS[v].look;
      #1 check(VECS[v].expCls, int'(VECS[v].req), $sformatf("vector %0d", v));
    end

    // R7 same-cycle lookup and update: raise entry 0x50 to 239
    for (int k = 0; k < 111; k++) begin
      @(negedge clk); updPc = 32'h50; reuseHit = 1'b1;
    end
    @(negedge clk);
    reuseHit = 1'b0; lookPc = 32'h50;
    #1 check(3'd3, 7, "at 239 before");
    @(negedge clk);
    updPc = 32'h50; reuseHit = 1'b1;
    #1 check(3'd3, 7, "same cycle sees old class");
    @(negedge clk);
    reuseHit = 1'b0;
    #1 check(3'd4, 7, "after edge sees new class");

    // R5 index bits 17:9 fold: 0x20000 (bit 17) hashes to 0x100
    for (int k = 0; k < 33; k++) begin
      @(negedge clk); updPc = 32'h2_0000; firstTouch = 1'b1;
    end
    @(negedge clk);
    firstTouch = 1'b0; lookPc = 32'h100;
    #1 check(3'd1, 5, "bit 17 folds onto bit 8");

    // R1 reset again restores trained entries
    resetDut();
    lookPc = 32'h10; #1 check(3'd2, 1, "re-reset entry 0x10");
    lookPc = 32'h20; #1 check(3'd2, 1, "re-reset entry 0x20");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule